// File: doc/BRIEF.md
# Interrupt Line Aggregator with Message Signalling

This block gathers eleven interrupt lines from peripherals into one processor interrupt, delivered as a posted message write. Each line passes through a two-flop synchronizer. Software sees the current line levels in a live-level register and chooses which lines may interrupt through a mask register. When an enabled line changes level, in either direction, the block records the change in a request register that clears when read. It then queues one message write to a programmable target.

A pending register records changes on every implemented line, whether or not the line is enabled. It also clears when read. Neither of these clearing reads affects the live levels.

A trigger register lets software send the message again on demand. The usual case is a line that is still asserted when software unmasks it, because unmasking alone sends nothing.

The message leaves through a valid/ready port. While the port is stalled, at most one further message waits behind the one on the port. Any requests beyond that merge into the waiting one.

The register bus is a single-cycle access port. For a read, `bus_rdata` is registered and valid from the clock edge that accepts the read until the next read.

Top module: `irq_msg_agg`

## Requirements
- R1: After reset, every register reads zero and `msg_valid` is low.
- R2: The live register at offset 0x28 shows line i in bit i after a two-flop synchronizer. Reading any register does not change it. Writes to it are ignored.
- R3: The mask register at offset 0x18 is read/write and holds 11 bits; upper write bits are dropped. A 1 in bit i enables line i.
- R4: A level change in either direction on an enabled, implemented line does two things:
  - it sets bit i of the request register at offset 0x0C;
  - it queues exactly one message.
  The implemented lines form the set 0x5FF, so line 9 never sets a request bit or raises a message.
- R5: A read of the request register returns the latched bits and clears them. A second read with no new change returns zero.
- R6: A change on a masked line sets no request bit and sends no message. A line that is already asserted when it becomes enabled sends nothing until it next changes.
- R7: The pending register at offset 0x1C records changes on any implemented line, regardless of the mask. A read returns it and clears it, and leaves the live register unchanged.
- R8: The target register at offset 0x04 is a 32-bit read/write word holding address and data combined. A message carries:
  - as its address, the target with its low 5 bits cleared;
  - as its data, those low 5 bits, zero-extended.
- R9: Any write to the trigger offset 0x20 queues exactly one message, whatever the line states.
- R10: The message port holds `msg_valid` and its payload stable until `msg_ready` is sampled high. One further message is queued behind it. Any more requests made while both places are full merge into the queued one.
- R11: Offsets that map no register read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 11 | Asynchronous interrupt lines |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| msg_valid | output | 1 | Message write is offered |
| msg_ready | input | 1 | Message write is accepted |
| msg_addr | output | 32 | Message target address |
| msg_data | output | 32 | Message data word |

## Verification
On every cycle the assertions check four things:
- the live register follows the synchronizer's first stage one cycle later;
- a request read with no coincident change leaves the request register empty;
- any enabled change, or any queue request, is followed by a valid message;
- a stalled message holds its payload.

Only the bench's scenarios can show the rest:
- the per-line sweeps, which cover both edges, the bit-9 hole and the clearing reads;
- the pending/live independence;
- the masked-then-enabled case;
- the exact number of messages that come out after a stall.

// File: rtl/irq_agg_pkg.sv
// Package: register offsets and helpers shared by the aggregator modules.
// Assumes byte offsets on an 8-bit register bus.
package irq_agg_pkg;
    localparam logic [7:0] OFS_TARGET  = 8'h04;
    localparam logic [7:0] OFS_REQUEST = 8'h0C;
    localparam logic [7:0] OFS_MASK    = 8'h18;
    localparam logic [7:0] OFS_PENDING = 8'h1C;
    localparam logic [7:0] OFS_TRIGGER = 8'h20;
    localparam logic [7:0] OFS_LIVE    = 8'h28;
endpackage

// File: rtl/irq_agg_sync.sv
// Module: per-line two-flop synchronizer followed by a change detector.
// Assumes lines are asynchronous and that each pulse lasts at least three clocks.
module irq_agg_sync #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines_in,
    output logic [N-1:0] level_o,
    output logic [N-1:0] change_o
);
    logic [N-1:0] stage1;
    logic [N-1:0] prev;

    for (genvar i = 0; i < N; i++) begin : g_line
        // Two-flop synchronizer and one-cycle history for line i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1[i]  <= 1'b0;
                level_o[i] <= 1'b0;
                prev[i]    <= 1'b0;
            end else begin
                stage1[i]  <= lines_in[i];
                level_o[i] <= stage1[i];
                prev[i]    <= level_o[i];
            end
        end
    end

    // A change is any difference between the synchronized level and its history.
    assign change_o = level_o ^ prev;

    a_r2_live_delay: assert property (@(posedge clk) disable iff (!rst_n)
        level_o == $past(stage1))
        else $error("R2: live level does not follow synchronizer stage");
endmodule

// File: rtl/irq_agg_regs.sv
// Module: register file holding the target, mask, request, pending and live views.
// Assumes one access per bus_sel cycle; a read clears in the edge that returns data.
module irq_agg_regs
    import irq_agg_pkg::*;
#(
    parameter int N         = 11,
    parameter int DW        = 32,
    parameter int AW        = 8,
    parameter int IMPL_MASK = 'h5FF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [N-1:0]  level_i,
    input  logic [N-1:0]  change_i,
    output logic [N-1:0]  enable_o,
    output logic [DW-1:0] target_o,
    output logic          raise_o
);
    localparam logic [N-1:0] IMPL = IMPL_MASK[N-1:0];
    localparam int PADW = DW - N;

    logic [N-1:0]  mask_q;
    logic [N-1:0]  req_q;
    logic [N-1:0]  pend_q;
    logic [DW-1:0] target_q;
    logic          rd, wr;
    logic [N-1:0]  req_set, pend_set;
    logic          clr_req, clr_pend;
    logic [DW-1:0] rd_mux;

    assign rd       = bus_sel && !bus_wr;
    assign wr       = bus_sel && bus_wr;
    assign enable_o = mask_q & IMPL;
    assign req_set  = change_i & enable_o;
    assign pend_set = change_i & IMPL;
    assign clr_req  = rd && (bus_addr == OFS_REQUEST);
    assign clr_pend = rd && (bus_addr == OFS_PENDING);
    assign target_o = target_q;
    // One message per cycle with an enabled change or a trigger write.
    assign raise_o  = (|req_set) || (wr && bus_addr == OFS_TRIGGER);

    // Software-written target and mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q <= '0;
            mask_q   <= '0;
        end else if (wr) begin
            if (bus_addr == OFS_TARGET) target_q <= bus_wdata;
            if (bus_addr == OFS_MASK)   mask_q   <= bus_wdata[N-1:0];
        end
    end

    // Read-to-clear latches; a change in the clearing cycle survives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            pend_q <= '0;
        end else begin
            req_q  <= (clr_req  ? '0 : req_q)  | req_set;
            pend_q <= (clr_pend ? '0 : pend_q) | pend_set;
        end
    end

    // Read data selection by offset.
    always_comb begin
        case (bus_addr)
            OFS_TARGET:  rd_mux = target_q;
            OFS_REQUEST: rd_mux = {{PADW{1'b0}}, req_q};
            OFS_MASK:    rd_mux = {{PADW{1'b0}}, mask_q};
            OFS_PENDING: rd_mux = {{PADW{1'b0}}, pend_q};
            OFS_LIVE:    rd_mux = {{PADW{1'b0}}, level_i};
            default:     rd_mux = '0;
        endcase
    end

    // Registered read data port.
    always_ff @(posedge clk) begin
        if (!rst_n)  bus_rdata <= '0;
        else if (rd) bus_rdata <= rd_mux;
    end

    a_r5_req_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !(|req_set)) |=> (req_q == '0))
        else $error("R5: request register not cleared by read");
endmodule

// File: rtl/irq_agg_msgq.sv
// Module: one-slot message output with a one-deep queue behind it.
// Assumes all messages carry the same target, so surplus requests may merge.
module irq_agg_msgq #(
    parameter int DW    = 32,
    parameter int DBITS = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enq_i,
    input  logic [DW-1:0] target_i,
    output logic          valid_o,
    input  logic          ready_i,
    output logic [DW-1:0] addr_o,
    output logic [DW-1:0] data_o
);
    logic          slot_v;
    logic          spare_v;
    logic [DW-1:0] slot_w;
    logic          pop;

    assign pop     = slot_v && ready_i;
    assign valid_o = slot_v;
    assign addr_o  = {slot_w[DW-1:DBITS], {DBITS{1'b0}}};
    assign data_o  = {{(DW-DBITS){1'b0}}, slot_w[DBITS-1:0]};

    // Slot and queue update: pop refills from the queue, surplus merges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_v  <= 1'b0;
            spare_v <= 1'b0;
            slot_w  <= '0;
        end else if (pop) begin
            if (spare_v) begin
                slot_w  <= target_i;
                spare_v <= enq_i;
            end else begin
                slot_v <= enq_i;
                if (enq_i) slot_w <= target_i;
            end
        end else if (!slot_v) begin
            if (enq_i) begin
                slot_v <= 1'b1;
                slot_w <= target_i;
            end
        end else if (enq_i) begin
            spare_v <= 1'b1;
        end
    end

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_v && !ready_i) |=> (slot_v && $stable(slot_w)))
        else $error("R10: stalled message not held");

    a_r9_enq_valid: assert property (@(posedge clk) disable iff (!rst_n)
        enq_i |=> slot_v)
        else $error("R9: queued request produced no valid message");
endmodule

// File: rtl/irq_msg_agg.sv
// Module: top of the interrupt aggregator: synchronizer, registers, message queue.
// Assumes a single register bus master and a single message consumer.
module irq_msg_agg #(
    parameter int N         = 11,
    parameter int DW        = 32,
    parameter int AW        = 8,
    parameter int DBITS     = 5,
    parameter int IMPL_MASK = 'h5FF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_in,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          msg_valid,
    input  logic          msg_ready,
    output logic [DW-1:0] msg_addr,
    output logic [DW-1:0] msg_data
);
    logic [N-1:0]  level;
    logic [N-1:0]  change;
    logic [N-1:0]  enable;
    logic [DW-1:0] target;
    logic          raise;

    irq_agg_sync #(.N(N)) u_sync (
        .clk(clk), .rst_n(rst_n), .lines_in(irq_in),
        .level_o(level), .change_o(change)
    );

    irq_agg_regs #(.N(N), .DW(DW), .AW(AW), .IMPL_MASK(IMPL_MASK)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .level_i(level), .change_i(change),
        .enable_o(enable), .target_o(target), .raise_o(raise)
    );

    irq_agg_msgq #(.DW(DW), .DBITS(DBITS)) u_msgq (
        .clk(clk), .rst_n(rst_n), .enq_i(raise), .target_i(target),
        .valid_o(msg_valid), .ready_i(msg_ready),
        .addr_o(msg_addr), .data_o(msg_data)
    );

    a_r4_evt_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (|(change & enable)) |=> msg_valid)
        else $error("R4: enabled change raised no message");
endmodule

// File: tb/irq_msg_agg_bench.sv
module irq_msg_agg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] irq_in = '0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [31:0] msg_addr, msg_data;

    int vectors = 0;
    int errors  = 0;
    int msg_cnt = 0;
    logic [31:0] last_addr = '0, last_data = '0;

    localparam logic [31:0] IMPL   = 32'h5FF;
    localparam logic [31:0] TARGET = 32'hABCD_1234;

    irq_msg_agg u_irq_msg_agg (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    always #2 clk = ~clk;

    // Count accepted messages at the edge where the transfer happens.
    always @(posedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            msg_cnt   <= msg_cnt + 1;
            last_addr <= msg_addr;
            last_data <= msg_data;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        check(tag, bus_rdata, exp);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        int c0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 msg_valid", {31'b0, msg_valid}, 32'h0);
        reg_rd(8'h04, 32'h0, "R1 target");
        reg_rd(8'h0C, 32'h0, "R1 request");
        reg_rd(8'h18, 32'h0, "R1 mask");
        reg_rd(8'h1C, 32'h0, "R1 pending");
        reg_rd(8'h28, 32'h0, "R1 live");

        // R11 unmapped offsets; R2 writes to live ignored
        reg_rd(8'h08, 32'h0, "R11 offset 0x08");
        reg_rd(8'h40, 32'h0, "R11 offset 0x40");
        reg_wr(8'h28, 32'hFFFF_FFFF);
        reg_rd(8'h28, 32'h0, "R2 live write ignored");

        // R3 mask readback and width; R8 target readback
        reg_wr(8'h18, 32'hFFFF_FFFF);
        reg_rd(8'h18, 32'h7FF, "R3 mask width");
        reg_wr(8'h04, TARGET);
        reg_rd(8'h04, TARGET, "R8 target readback");

        // R4/R5/R7/R2 per-line sweep with all lines enabled
        for (int i = 0; i < 11; i++) begin
            logic [31:0] bit_i, impl_i;
            bit_i  = 32'h1 << i;
            impl_i = bit_i & IMPL;
            c0 = msg_cnt;
            @(negedge clk); irq_in[i] = 1'b1;
            settle();
            reg_rd(8'h0C, impl_i, "R4 rise request");
            check("R4 rise messages", msg_cnt - c0, (impl_i != 0) ? 1 : 0);
            reg_rd(8'h0C, 32'h0, "R5 request cleared");
            reg_rd(8'h28, bit_i, "R2 live level");
            reg_rd(8'h1C, impl_i, "R7 pending");
            reg_rd(8'h1C, 32'h0, "R7 pending cleared");
            reg_rd(8'h28, bit_i, "R7 live after pending read");
            c0 = msg_cnt;
            @(negedge clk); irq_in[i] = 1'b0;
            settle();
            reg_rd(8'h0C, impl_i, "R4 fall request");
            check("R4 fall messages", msg_cnt - c0, (impl_i != 0) ? 1 : 0);
            reg_rd(8'h1C, impl_i, "R7 pending on fall");
        end
        check("R8 msg address", last_addr, TARGET & 32'hFFFF_FFE0);
        check("R8 msg data", last_data, TARGET & 32'h1F);

        // R6 masked line and already-asserted line enabled later
        reg_wr(8'h18, 32'h0);
        c0 = msg_cnt;
        @(negedge clk); irq_in[2] = 1'b1;
        settle();
        reg_rd(8'h0C, 32'h0, "R6 masked request");
        check("R6 masked messages", msg_cnt - c0, 0);
        reg_rd(8'h1C, 32'h4, "R7 masked pending");
        reg_wr(8'h18, 32'h4);
        settle();
        reg_rd(8'h0C, 32'h0, "R6 enable while asserted");
        check("R6 enable messages", msg_cnt - c0, 0);
        @(negedge clk); irq_in[2] = 1'b0;
        settle();
        reg_rd(8'h0C, 32'h4, "R6 later change");
        check("R6 later messages", msg_cnt - c0, 1);

        // R9 trigger
        c0 = msg_cnt;
        reg_wr(8'h20, 32'h0);
        settle();
        check("R9 trigger messages", msg_cnt - c0, 1);
        check("R9 trigger address", last_addr, 32'hABCD_1220);
        check("R9 trigger data", last_data, 32'h14);

        // R10 backpressure: three requests, two messages
        @(negedge clk); msg_ready = 1'b0;
        c0 = msg_cnt;
        reg_wr(8'h20, 32'h0);
        reg_wr(8'h20, 32'h0);
        reg_wr(8'h20, 32'h0);
        settle();
        check("R10 valid held", {31'b0, msg_valid}, 32'h1);
        check("R10 addr held", msg_addr, 32'hABCD_1220);
        check("R10 no transfer", msg_cnt - c0, 0);
        @(negedge clk); msg_ready = 1'b1;
        repeat (6) @(negedge clk);
        check("R10 merged count", msg_cnt - c0, 2);
        check("R10 idle", {31'b0, msg_valid}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule